// File: doc/BRIEF.md
# I2S Transmitter with Padded Frames

This block is the master side of an I2S output link. It produces three lines from a system clock: a bit clock that never stops, a word-select line, and a serial data line. It also has a valid/ready port that takes one left/right pair of 16-bit samples per frame. The bit clock is divided down from the system clock by an even ratio. Every register runs on the system clock and advances on enable pulses, so the block has no second clock domain.

There are two framing modes. In the balanced mode a frame is 32 bit periods long, and word select spends equal time on each channel. In the stretched mode the frame is longer than 32 bit periods. The extra periods come after the right channel's least significant bit. During them the data line stays low and the bit clock keeps running. Word select therefore stays high longer than it stays low. A system uses the stretched mode to run the bit clock at a rate that divides evenly from its source when the sample rate alone would not allow that.

Top module: `i2s_pad_tx`

## Requirements
- R1: While `rst_n` is low, at the next rising system-clock edge `bclk`, `ws`, `sdata` and `s_ready` all go low.
- R2: The bit clock starts low after reset and stays in each level for H system cycles, where H is `div_half`, or 1 when `div_half` is 0. Its period is therefore 2H and its duty cycle 50%, and it runs without gaps. `div_half` is changed only while reset is held.
- R3: A bit slot starts on the system edge where `bclk` falls, and `ws` and `sdata` change only on that edge. Slots 0 to 15 of a frame carry the left sample and slots 16 to 31 the right sample, each most significant bit first. So slot k carries bit 31-k of {left,right}.
- R4: With `accurate` low a frame is 32 slots long. `ws` is high in slots 15 to 30 and low in slot 31 and slots 0 to 14, which gives 16 slots at each level. `ws` low marks the left channel, and it changes one slot ahead of each channel's first bit.
- R5: With `accurate` high a frame is L slots long, where L is `frame_len`, or 32 when `frame_len` is below 32. `ws` is high in slots 15 to L-2 and low in slot L-1 and slots 0 to 14.
- R6: Slots 32 to L-1 are padding slots. In them `sdata` is 0, and the bit clock keeps toggling.
- R7: `s_ready` is high for exactly the one system cycle whose closing edge starts a frame (the first frame starts at the first falling `bclk` after reset). If `s_valid` is high in that cycle, `s_left`/`s_right` are sent in that frame. If it is low, zeros are sent on both channels.
- R8: `accurate` and `frame_len` are sampled only when a frame starts. A change in the middle of a frame first takes effect in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| div_half | input | DIV_W | System cycles per bit-clock half period (0 acts as 1) |
| accurate | input | 1 | 1 selects stretched framing with padding slots |
| frame_len | input | LEN_W | Frame length in bit slots for the stretched mode (minimum 32) |
| s_valid | input | 1 | Sample pair is offered |
| s_left | input | 16 | Left-channel sample |
| s_right | input | 16 | Right-channel sample |
| s_ready | output | 1 | Pair is taken in this cycle |
| bclk | output | 1 | Continuous serial bit clock |
| ws | output | 1 | Word select (0 = left, 1 = right) |
| sdata | output | 1 | Serial data |

## Verification
The bench first sends balanced frames carrying changing, non-symmetric sample values, which shows whether the bit order and the channel order are correct. It then withholds `s_valid`, which separates zero-filling from resending a stale pair. The stretched mode is exercised with frame lengths of 40, 64 and 20, with one change made in the middle of a frame. These runs show whether the padding length follows the input, whether the floor of 32 is applied, and whether a new length waits for the next frame boundary. Divider settings of 2, 0 and 3 show whether the bit-clock timing is independent of the framing.

// File: rtl/i2s_pad_pkg.sv
`timescale 1ns/1ps
// Package: shared sizes for the padded-frame I2S transmitter.
// Assumes a fixed 16-bit channel word; the frame floor follows from it.
package i2s_pad_pkg;
    localparam int CH_BITS   = 16;
    localparam int PAIR_BITS = 2 * CH_BITS;
    localparam int MIN_FRAME = PAIR_BITS;
endpackage

// File: rtl/i2s_bclk_gen.sv
`timescale 1ns/1ps
// Module: i2s_bclk_gen
// Divides the system clock into a free-running bit clock held as a plain
// register output, and flags the system cycle whose closing edge drives
// the bit clock low (the start of a bit slot).
// Assumes div_half only changes while reset is held; 0 is treated as 1.
module i2s_bclk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_half,
    output logic             bclk,
    output logic             fall_evt
);
    logic [DIV_W-1:0] half_cnt;
    logic [DIV_W-1:0] half_len;
    logic             half_done;

    // Effective half-period length, with zero clamped to one cycle.
    always_comb half_len = (div_half == '0) ? DIV_W'(1) : div_half;

    // End of the current half period and the falling-edge strobe.
    always_comb begin
        half_done = (half_cnt >= half_len - DIV_W'(1));
        fall_evt  = half_done & bclk;
    end

    // Half-period counter and bit-clock toggle register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_cnt <= '0;
            bclk     <= 1'b0;
        end else if (half_done) begin
            half_cnt <= '0;
            bclk     <= ~bclk;
        end else begin
            half_cnt <= half_cnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/i2s_frame_seq.sv
`timescale 1ns/1ps
// Module: i2s_frame_seq
// Counts bit slots within a frame, latches the frame length at each frame
// start, and drives word select and the padding-slot flag for every slot.
// Assumes fall_evt marks slot boundaries; LEN_W must hold at least 32.
module i2s_frame_seq
    import i2s_pad_pkg::*;
#(
    parameter int LEN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall_evt,
    input  logic             accurate,
    input  logic [LEN_W-1:0] frame_len,
    output logic             frame_start,
    output logic             ws,
    output logic             dummy,
    output logic [LEN_W-1:0] slot,
    output logic [LEN_W-1:0] cur_len
);
    localparam logic [LEN_W-1:0] MIN_LEN  = LEN_W'(MIN_FRAME);
    localparam logic [LEN_W-1:0] WS_EARLY = LEN_W'(CH_BITS - 1);

    logic             running;
    logic [LEN_W-1:0] next_len;
    logic [LEN_W-1:0] next_slot;
    logic             next_ws;

    // Frame length that applies from the next frame start.
    always_comb begin
        if (!accurate)
            next_len = MIN_LEN;
        else if (frame_len < MIN_LEN)
            next_len = MIN_LEN;
        else
            next_len = frame_len;
    end

    // Frame boundary detection and word select for the following slot.
    always_comb begin
        frame_start = fall_evt & (~running | (slot == cur_len - LEN_W'(1)));
        next_slot   = slot + LEN_W'(1);
        next_ws     = (next_slot >= WS_EARLY) && (next_slot <= cur_len - LEN_W'(2));
    end

    // Slot counter, latched length, and registered per-slot outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            slot    <= '0;
            cur_len <= MIN_LEN;
            ws      <= 1'b0;
            dummy   <= 1'b0;
        end else if (frame_start) begin
            running <= 1'b1;
            slot    <= '0;
            cur_len <= next_len;
            ws      <= 1'b0;
            dummy   <= 1'b0;
        end else if (fall_evt) begin
            slot    <= next_slot;
            ws      <= next_ws;
            dummy   <= (next_slot >= MIN_LEN);
        end
    end
endmodule

// File: rtl/i2s_tx_shift.sv
`timescale 1ns/1ps
// Module: i2s_tx_shift
// Parallel-load shift register feeding the serial data line MSB first.
// Zeros fill in behind the word, so padding slots come out low.
// Assumes load coincides with a slot boundary.
module i2s_tx_shift #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fall_evt,
    input  logic         load,
    input  logic [W-1:0] pair,
    output logic         sdata
);
    logic [W-1:0] sreg;

    // Load a new word at frame start, otherwise shift one bit per slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg  <= '0;
            sdata <= 1'b0;
        end else if (load) begin
            sdata <= pair[W-1];
            sreg  <= {pair[W-2:0], 1'b0};
        end else if (fall_evt) begin
            sdata <= sreg[W-1];
            sreg  <= {sreg[W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/i2s_pad_tx.sv
`timescale 1ns/1ps
// Module: i2s_pad_tx (top)
// I2S master transmitter with balanced or padded (stretched) framing.
// Takes one left/right pair per frame via valid/ready; sends zeros when
// no pair is offered. Assumes div_half is changed only under reset.
module i2s_pad_tx
    import i2s_pad_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int LEN_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DIV_W-1:0]   div_half,
    input  logic               accurate,
    input  logic [LEN_W-1:0]   frame_len,
    input  logic               s_valid,
    input  logic [CH_BITS-1:0] s_left,
    input  logic [CH_BITS-1:0] s_right,
    output logic               s_ready,
    output logic               bclk,
    output logic               ws,
    output logic               sdata
);
    logic                 fall_evt;
    logic                 frame_start;
    logic                 pad_slot;
    logic [LEN_W-1:0]     slot_idx;
    logic [LEN_W-1:0]     frame_slots;
    logic [PAIR_BITS-1:0] tx_pair;

    // Word offered to the shifter: the sample pair, or silence.
    always_comb begin
        tx_pair = s_valid ? {s_left, s_right} : '0;
        s_ready = frame_start;
    end

    i2s_bclk_gen #(.DIV_W(DIV_W)) u_bclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_half (div_half),
        .bclk     (bclk),
        .fall_evt (fall_evt)
    );

    i2s_frame_seq #(.LEN_W(LEN_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .fall_evt    (fall_evt),
        .accurate    (accurate),
        .frame_len   (frame_len),
        .frame_start (frame_start),
        .ws          (ws),
        .dummy       (pad_slot),
        .slot        (slot_idx),
        .cur_len     (frame_slots)
    );

    i2s_tx_shift #(.W(PAIR_BITS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .fall_evt (fall_evt),
        .load     (frame_start),
        .pair     (tx_pair),
        .sdata    (sdata)
    );
endmodule

// File: rtl/i2s_pad_tx_chk.sv
`timescale 1ns/1ps
// Module: i2s_pad_tx_chk
// Assertion checker bound to i2s_pad_tx. Watches the output lines, the
// handshake and the sequencer's slot state. Assumes div_half is steady
// outside reset.
module i2s_pad_tx_chk #(
    parameter int DIV_W = 8,
    parameter int LEN_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DIV_W-1:0] div_half,
    input logic             bclk,
    input logic             ws,
    input logic             sdata,
    input logic             s_ready,
    input logic             pad_slot,
    input logic [LEN_W-1:0] slot_idx,
    input logic [LEN_W-1:0] frame_slots
);
    logic             bclk_q;
    logic [DIV_W:0]   lvl_cnt;
    logic [DIV_W:0]   half_exp;

    // Expected length of each bit-clock level in system cycles.
    always_comb half_exp = (div_half == '0) ? (DIV_W+1)'(1) : {1'b0, div_half};

    // Count how long the bit clock has held its current level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q  <= 1'b0;
            lvl_cnt <= '0;
        end else begin
            bclk_q <= bclk;
            if (bclk != bclk_q)
                lvl_cnt <= (DIV_W+1)'(1);
            else if (lvl_cnt != '1)
                lvl_cnt <= lvl_cnt + (DIV_W+1)'(1);
        end
    end

    AST_BCLK_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk != bclk_q) |-> (lvl_cnt == half_exp)); // R2
    AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdata) |-> $fell(bclk)); // R3
    AST_WS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ws) |-> $fell(bclk)); // R4
    AST_SLOT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_idx < frame_slots) && (frame_slots >= LEN_W'(32))); // R5
    AST_PAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        pad_slot |-> !sdata); // R6
    AST_READY_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |=> $fell(bclk)); // R7
endmodule

bind i2s_pad_tx i2s_pad_tx_chk #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .div_half    (div_half),
    .bclk        (bclk),
    .ws          (ws),
    .sdata       (sdata),
    .s_ready     (s_ready),
    .pad_slot    (pad_slot),
    .slot_idx    (slot_idx),
    .frame_slots (frame_slots)
);

// File: tb/tb_i2s_pad_tx.sv
`timescale 1ns/1ps
// Bench: behavioural slot-queue reference model, compared every cycle.
module tb_i2s_pad_tx;
    localparam int DIV_W = 8;
    localparam int LEN_W = 7;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [DIV_W-1:0] div_half;
    logic             accurate;
    logic [LEN_W-1:0] frame_len;
    logic             s_valid;
    logic [15:0]      s_left, s_right;
    logic             s_ready, bclk, ws, sdata;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    // reference model state
    int  mcnt, mslot, mlen, dcur;
    bit  mbclk, mws, msd, took, exp_ready;
    int  q[$];
    int  ent;
    logic [31:0] pv;

    always #10 clk = ~clk; // 50 MHz

    i2s_pad_tx #(.DIV_W(DIV_W), .LEN_W(LEN_W)) dut (
        .clk(clk), .rst_n(rst_n), .div_half(div_half), .accurate(accurate),
        .frame_len(frame_len), .s_valid(s_valid), .s_left(s_left),
        .s_right(s_right), .s_ready(s_ready), .bclk(bclk), .ws(ws), .sdata(sdata)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Reference model: one bit slot per bclk period, frame built as a queue.
    always @(posedge clk) begin
        if (!rst_n) begin
            mcnt = 0; mbclk = 0; mws = 0; msd = 0; mslot = 0; took = 0;
            q.delete();
        end else begin
            dcur = (div_half == 0) ? 1 : int'(div_half);
            took = 0;
            if (mcnt + 1 >= dcur) begin
                mcnt = 0;
                if (mbclk) begin
                    if (q.size() == 0) begin
                        mlen = accurate ? ((int'(frame_len) < 32) ? 32 : int'(frame_len)) : 32;
                        pv   = s_valid ? {s_left, s_right} : 32'h0;
                        took = s_valid;
                        for (int k = 0; k < mlen; k++) begin
                            ent = k * 4;
                            if (k >= 15 && k <= mlen - 2) ent += 2;
                            if (k < 32 && pv[31-k]) ent += 1;
                            q.push_back(ent);
                        end
                    end
                    ent   = q.pop_front();
                    mws   = ent[1];
                    msd   = ent[0];
                    mslot = ent / 4;
                    mbclk = 0;
                end else begin
                    mbclk = 1;
                end
            end else begin
                mcnt++;
            end
        end
    end

    // Compare on every clock, away from the active edge; advance sample data.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            dcur      = (div_half == 0) ? 1 : int'(div_half);
            exp_ready = (mcnt + 1 >= dcur) && mbclk && (q.size() == 0);
            chk(bclk == mbclk, "R2 bclk", bclk, mbclk);
            chk(ws == mws, accurate ? "R5/R8 ws" : "R4 ws", ws, mws);
            chk(sdata == msd, (mslot >= 32) ? "R6 pad sdata" : "R3 sdata", sdata, msd);
            chk(s_ready == exp_ready, "R7 s_ready", s_ready, exp_ready);
        end
        if (took) begin
            s_left  = {s_left[14:0], s_left[15] ^ s_left[13] ^ s_left[12] ^ s_left[10]};
            s_right = s_right + 16'h2B1D;
            took    = 0;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            summary();
        end
    end

    task automatic reset_check();
        chk(bclk == 0,    "R1 bclk",    bclk,    0);
        chk(ws == 0,      "R1 ws",      ws,      0);
        chk(sdata == 0,   "R1 sdata",   sdata,   0);
        chk(s_ready == 0, "R1 s_ready", s_ready, 0);
    endtask

    initial begin
        rst_n = 0; div_half = 2; accurate = 0; frame_len = 32;
        s_valid = 1; s_left = 16'hA5C3; s_right = 16'h3C51;
        repeat (3) @(negedge clk);
        reset_check();                               // R1
        rst_n = 1;
        repeat (520) @(negedge clk);                 // R3, R4 balanced frames
        s_valid = 0;
        repeat (260) @(negedge clk);                 // R7 zero fill
        s_valid = 1; accurate = 1; frame_len = 40;   // R5, R6 stretched
        repeat (501) @(negedge clk);
        frame_len = 64;                              // R8 mid-frame change
        repeat (777) @(negedge clk);
        frame_len = 20;                              // R5 floor of 32
        repeat (300) @(negedge clk);
        accurate = 0;                                // R8 back to balanced
        repeat (300) @(negedge clk);
        rst_n = 0; div_half = 0; accurate = 1; frame_len = 64;
        repeat (3) @(negedge clk);
        reset_check();                               // R1 again
        rst_n = 1;
        repeat (420) @(negedge clk);                 // R2 zero divider
        rst_n = 0; div_half = 3; accurate = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (400) @(negedge clk);                 // R2 odd divider
        done = 1;
        summary();
    end
endmodule